// File: doc/BRIEF.md
# Two-Stage Watchdog Controller with Reset-Cause Flags

This block watches a free-running count of system clocks. When the count reaches a time-out chosen on a select input, the block raises a time-out flag. It requests an interrupt when the external enable is high. A fixed delay later it emits a one-clock system reset request, unless software restarts the count in between. Automatic resets happen only when software has enabled them.

One 8-bit control/status word is reached over a simple register port with a 1-bit address. Address 0 is the control word and address 1 is the key register. Some fields are protected: a write to them takes effect only inside a short window that is opened by a two-byte key sequence. The word also keeps flags that record why the system was last reset. Power-on, external and watchdog resets each treat these flags differently.

The register port has no stream data, so there is no valid/ready handshake. A write is a single-cycle strobe, and the read data is a combinational view of the addressed register.

Top module: `wdt_ctrl`

## Requirements
- R1: At address 0 the read word is {bit7 baud-double, bit6 power-up flag, bits 5:4 zero, bit3 time-out flag, bit2 watchdog-cause flag, bit1 reset enable, bit0 restart}. Bits 5:4 read 0 whatever is written to them. Address 1 reads 0.
- R2: An asynchronous power-on reset gives 0x40, with irq_o and sys_rst_o low. The power-up flag then stays at 1 until a protected write clears it.
- R3: Counting starts from the restart. After 2^(BASE_LOG2+STEP_LOG2*tmo_sel_i) clocks the time-out flag is set, whether or not interrupts are enabled. irq_o equals the time-out flag AND irq_en_i.
- R4: sys_rst_o pulses for exactly one clock, RST_DLY clocks after the time-out event, and only when the reset enable is 1. With the enable at 0, no pulse is emitted.
- R5: A protected write with bit 0 set makes the restart bit read 1 for one clock, then 0. It restarts the count and cancels a pending reset delay.
- R6: Writing 0xAA and then 0x55 to address 1 on consecutive clocks opens a window of OPEN_CLKS clocks. Bits 6, 3, 1 and 0 change only when written inside the window. The first write to address 0 closes the window.
- R7: Bits 7 and 2 take every write to address 0, with or without the window.
- R8: A watchdog reset sets the watchdog-cause flag. It clears the baud-double, time-out and restart bits, closes the window and restarts the count.
- R9: A synchronous external reset clears the baud-double, time-out and restart bits, closes the window and restarts the count. It leaves the power-up flag, the watchdog-cause flag and the reset enable unchanged.
- R10: If a time-out occurs in the same clock as a software write that clears the time-out flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_rst_i | input | 1 | Power-on reset, asynchronous, active high |
| ext_rst_i | input | 1 | External reset, synchronous, active high |
| reg_addr_i | input | 1 | 0 = control word, 1 = key register |
| reg_wr_i | input | 1 | Write strobe, one write per clock |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| tmo_sel_i | input | SEL_W | Time-out period select |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | One-clock system reset request |

## Verification
A behavioural model in the bench is compared with the outputs on every clock. The time-out is measured from a restart at two select values, which tells apart a period that is right from one that is off by a clock or taken from the wrong select entry. The key sequence is tried complete, broken by an idle clock, on the last open clock and one clock late, which tells the length of the window apart from how it is opened. A clear of the time-out flag is placed on the exact clock of a time-out, and an external reset is compared with a watchdog reset, which separates which flags each reset type keeps.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [REG_W-1:0] KEY_SECOND = 8'h55;

  localparam int BIT_BAUD  = 7;
  localparam int BIT_PWR   = 6;
  localparam int BIT_TMO   = 3;
  localparam int BIT_CAUSE = 2;
  localparam int BIT_EN    = 1;
  localparam int BIT_KICK  = 0;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_KEY = 1'b1} reg_sel_e;

  // layout of the control word as read (bits 7 down to 0)
  typedef struct packed {
    logic       baud2x;
    logic       pwr_flag;
    logic [1:0] spare;
    logic       tmo_flag;
    logic       cause_wd;
    logic       rst_en;
    logic       kick;
  } wdctl_t;

  // writable fields only
  typedef struct packed {
    logic baud2x;
    logic pwr_flag;
    logic tmo_flag;
    logic cause_wd;
    logic rst_en;
    logic kick;
  } wdwr_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int OPEN_CLKS = 3
) (
  input  logic             clk_i,
  input  logic             pwr_rst_i,
  input  logic             clr_i,
  input  logic             key_wr_i,
  input  logic [REG_W-1:0] key_i,
  input  logic             ctl_wr_i,
  output logic             open_o
);
  localparam int WIN_W = $clog2(OPEN_CLKS + 1);
  localparam logic [WIN_W-1:0] WIN_FULL = WIN_W'(OPEN_CLKS);

  logic             armed_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or posedge pwr_rst_i) begin
    if (pwr_rst_i) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= key_wr_i && (key_i == KEY_FIRST);
      if (key_wr_i && (key_i == KEY_SECOND) && armed_q)
        win_q <= WIN_FULL;
      else if (ctl_wr_i)
        win_q <= '0;
      else if (win_q != '0)
        win_q <= win_q - 1'b1;
    end
  end

  assign open_o = (win_q != '0);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int BASE_LOG2 = 17,
  parameter int STEP_LOG2 = 3,
  parameter int SEL_W     = 2,
  parameter int RST_DLY   = 512
) (
  input  logic             clk_i,
  input  logic             pwr_rst_i,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] tsel_i,
  output logic             hit_o,
  output logic             fire_o,
  output logic             rst_pulse_o
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);
  localparam int DLY_W = $clog2(RST_DLY);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);
  localparam logic [CNT_W:0]   ONE      = 1;

  logic [CNT_W-1:0] lim_tab [NSEL];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dcnt_q;
  logic             dact_q;
  logic             pulse_q;

  // one terminal count per select value
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    localparam int SH = BASE_LOG2 + STEP_LOG2 * g;
    assign lim_tab[g] = CNT_W'((ONE << SH) - ONE);
  end

  assign lim    = lim_tab[tsel_i];
  assign hit_o  = !restart_i && (cnt_q == lim);
  assign fire_o = dact_q && (dcnt_q == DLY_LAST) && en_i && !restart_i;

  always_ff @(posedge clk_i or posedge pwr_rst_i) begin
    if (pwr_rst_i) begin
      cnt_q   <= '0;
      dcnt_q  <= '0;
      dact_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (clr_i || fire_o) begin
      cnt_q   <= '0;
      dcnt_q  <= '0;
      dact_q  <= 1'b0;
      pulse_q <= fire_o && !clr_i;
    end else begin
      pulse_q <= 1'b0;
      cnt_q   <= (restart_i || hit_o) ? '0 : cnt_q + 1'b1;
      if (restart_i) begin
        dact_q <= 1'b0;
        dcnt_q <= '0;
      end else if (hit_o) begin
        dact_q <= 1'b1;
        dcnt_q <= '0;
      end else if (dact_q) begin
        if (dcnt_q == DLY_LAST) begin
          dact_q <= 1'b0;
          dcnt_q <= '0;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  assign rst_pulse_o = pulse_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic   clk_i,
  input  logic   pwr_rst_i,
  input  logic   ext_rst_i,
  input  logic   fire_i,
  input  logic   hit_i,
  input  logic   ctl_wr_i,
  input  logic   open_i,
  input  wdwr_t  wr_i,
  output wdctl_t ctl_o
);
  logic baud_q, pwr_q, tmo_q, cause_q, en_q, kick_q;

  always_ff @(posedge clk_i or posedge pwr_rst_i) begin
    if (pwr_rst_i) begin
      baud_q  <= 1'b0;
      pwr_q   <= 1'b1;
      tmo_q   <= 1'b0;
      cause_q <= 1'b0;
      en_q    <= 1'b0;
      kick_q  <= 1'b0;
    end else if (ext_rst_i) begin
      baud_q <= 1'b0;
      tmo_q  <= 1'b0;
      kick_q <= 1'b0;
    end else if (fire_i) begin
      baud_q  <= 1'b0;
      tmo_q   <= 1'b0;
      kick_q  <= 1'b0;
      cause_q <= 1'b1;
    end else begin
      kick_q <= ctl_wr_i && open_i && wr_i.kick;
      if (ctl_wr_i) begin
        baud_q  <= wr_i.baud2x;
        cause_q <= wr_i.cause_wd;
        if (open_i) begin
          pwr_q <= wr_i.pwr_flag;
          en_q  <= wr_i.rst_en;
          tmo_q <= wr_i.tmo_flag;
        end
      end
      if (hit_i) tmo_q <= 1'b1;
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o.baud2x   = baud_q;
    ctl_o.pwr_flag = pwr_q;
    ctl_o.tmo_flag = tmo_q;
    ctl_o.cause_wd = cause_q;
    ctl_o.rst_en   = en_q;
    ctl_o.kick     = kick_q;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 17,
  parameter int STEP_LOG2 = 3,
  parameter int SEL_W     = 2,
  parameter int RST_DLY   = 512,
  parameter int OPEN_CLKS = 3
) (
  input  logic             clk_i,
  input  logic             pwr_rst_i,
  input  logic             ext_rst_i,
  input  logic             reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [SEL_W-1:0] tmo_sel_i,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             sys_rst_o
);
  wdctl_t ctl;
  wdwr_t  wr_f;
  logic   ctl_wr, key_wr, key_open;
  logic   hit, fire;

  assign ctl_wr = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_CTRL);
  assign key_wr = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_KEY);

  assign wr_f.baud2x   = reg_wdata_i[BIT_BAUD];
  assign wr_f.pwr_flag = reg_wdata_i[BIT_PWR];
  assign wr_f.tmo_flag = reg_wdata_i[BIT_TMO];
  assign wr_f.cause_wd = reg_wdata_i[BIT_CAUSE];
  assign wr_f.rst_en   = reg_wdata_i[BIT_EN];
  assign wr_f.kick     = reg_wdata_i[BIT_KICK];

  wdt_unlock #(.OPEN_CLKS(OPEN_CLKS)) u_unlock (
    .clk_i    (clk_i),
    .pwr_rst_i(pwr_rst_i),
    .clr_i    (ext_rst_i || fire),
    .key_wr_i (key_wr),
    .key_i    (reg_wdata_i),
    .ctl_wr_i (ctl_wr),
    .open_o   (key_open)
  );

  wdt_timer #(
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2),
    .SEL_W(SEL_W), .RST_DLY(RST_DLY)
  ) u_timer (
    .clk_i      (clk_i),
    .pwr_rst_i  (pwr_rst_i),
    .clr_i      (ext_rst_i),
    .restart_i  (ctl.kick),
    .en_i       (ctl.rst_en),
    .tsel_i     (tmo_sel_i),
    .hit_o      (hit),
    .fire_o     (fire),
    .rst_pulse_o(sys_rst_o)
  );

  wdt_regs u_regs (
    .clk_i    (clk_i),
    .pwr_rst_i(pwr_rst_i),
    .ext_rst_i(ext_rst_i),
    .fire_i   (fire),
    .hit_i    (hit),
    .ctl_wr_i (ctl_wr),
    .open_i   (key_open),
    .wr_i     (wr_f),
    .ctl_o    (ctl)
  );

  assign reg_rdata_o = (reg_sel_e'(reg_addr_i) == SEL_CTRL) ? ctl : '0;
  assign irq_o       = ctl.tmo_flag & irq_en_i;
endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk
  import wdt_pkg::*;
(
  input logic   clk_i,
  input logic   pwr_rst_i,
  input logic   sys_rst_o,
  input logic   irq_o,
  input wdctl_t ctl_q,
  input logic   key_open
);
  // R4
  rst_single_pulse_chk: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    sys_rst_o |=> !sys_rst_o);

  // R4
  rst_needs_enable_chk: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    sys_rst_o |-> ctl_q.rst_en);

  // R8
  rst_sets_cause_chk: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    sys_rst_o |-> (ctl_q.cause_wd && !ctl_q.tmo_flag));

  // R5
  kick_self_clear_chk: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    ctl_q.kick |=> !ctl_q.kick);

  // R6
  locked_bits_hold_chk: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    !key_open |=> $stable({ctl_q.rst_en, ctl_q.pwr_flag}));

  // R3
  irq_from_flag_chk: assert property (@(posedge clk_i) disable iff (pwr_rst_i)
    irq_o |-> ctl_q.tmo_flag);
endmodule

bind wdt_ctrl wdt_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .pwr_rst_i(pwr_rst_i),
  .sys_rst_o(sys_rst_o),
  .irq_o    (irq_o),
  .ctl_q    (ctl),
  .key_open (key_open)
);

// File: tb/sim_wdt_ctrl.sv
module sim_wdt_ctrl;
  localparam int CLK_P = 10;
  localparam int B     = 10;
  localparam int S     = 1;
  localparam int DLY   = 512;
  localparam int WIN   = 3;

  logic       clk = 1'b0;
  logic       pwr_rst = 1'b1, ext_rst = 1'b0;
  logic       addr = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] tsel = 2'd0;
  logic       irq_en = 1'b0;
  logic       irq, rst;

  int n_cmp = 0, n_bad = 0, obs_pulses = 0;

  // behavioural reference state
  bit m_baud = 0, m_pf = 1, m_tf = 0, m_wf = 0, m_en = 0, m_kick = 0;
  bit m_rstp = 0, m_dact = 0, m_aa = 0;
  int m_cnt = 0, m_dcnt = 0, m_win = 0;

  wdt_ctrl #(.BASE_LOG2(B), .STEP_LOG2(S), .SEL_W(2), .RST_DLY(DLY), .OPEN_CLKS(WIN)) u0 (
    .clk_i(clk), .pwr_rst_i(pwr_rst), .ext_rst_i(ext_rst),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tmo_sel_i(tsel), .irq_en_i(irq_en), .irq_o(irq), .sys_rst_o(rst)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_img();
    return {m_baud, m_pf, 2'b00, m_tf, m_wf, m_en, m_kick};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // model step on each rising edge
  always @(posedge clk) begin
    int per;
    bit restart, hit, fire, cw, kw, open;
    if (pwr_rst) begin
      m_baud = 0; m_pf = 1; m_tf = 0; m_wf = 0; m_en = 0; m_kick = 0;
      m_rstp = 0; m_dact = 0; m_aa = 0; m_cnt = 0; m_dcnt = 0; m_win = 0;
    end else if (ext_rst) begin
      m_baud = 0; m_tf = 0; m_kick = 0; m_rstp = 0;
      m_cnt = 0; m_dact = 0; m_dcnt = 0; m_win = 0; m_aa = 0;
    end else begin
      per     = 1 << (B + S * int'(tsel));
      restart = m_kick;
      hit     = !restart && (m_cnt == per - 1);
      fire    = m_dact && (m_dcnt == DLY - 1) && m_en && !restart;
      cw      = wr && !addr;
      kw      = wr && addr;
      open    = m_win > 0;
      if (fire) begin
        m_rstp = 1; m_wf = 1; m_baud = 0; m_tf = 0; m_kick = 0;
        m_cnt = 0; m_dact = 0; m_dcnt = 0; m_win = 0; m_aa = 0;
      end else begin
        m_rstp = 0;
        m_cnt  = (restart || hit) ? 0 : m_cnt + 1;
        if (restart) begin m_dact = 0; m_dcnt = 0; end
        else if (hit) begin m_dact = 1; m_dcnt = 0; end
        else if (m_dact) begin
          if (m_dcnt == DLY - 1) begin m_dact = 0; m_dcnt = 0; end
          else m_dcnt++;
        end
        m_kick = cw && open && wdata[0];
        if (cw) begin
          m_baud = wdata[7]; m_wf = wdata[2];
          if (open) begin m_pf = wdata[6]; m_en = wdata[1]; m_tf = wdata[3]; end
        end
        if (hit) m_tf = 1;
        if (kw && wdata == 8'h55 && m_aa) m_win = WIN;
        else if (cw) m_win = 0;
        else if (m_win > 0) m_win--;
        m_aa = kw && (wdata == 8'hAA);
      end
    end
  end

  // per-clock comparison, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (!pwr_rst) begin
      if (rst) obs_pulses++;
      if (!addr) check("R1 register image", rdata, exp_img());
      check("R3 irq output", irq, m_tf & irq_en);
      check("R4 reset request", rst, m_rstp);
    end
  end

  task automatic put(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    addr = 1'b0; wdata = '0; wr = 1'b0;
  endtask

  task automatic unlock();
    put(1'b1, 8'hAA);
    put(1'b1, 8'h55);
  endtask

  task automatic chk_img(input string tag, input logic [7:0] exp);
    idle();
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n, o0;
    repeat (3) @(negedge clk);
    pwr_rst = 1'b0;
    // R2 reset state
    chk_img("R2 power-on image", 8'h40);
    check("R2 irq low", irq, 0);
    check("R2 reset low", rst, 0);
    // R1 key address reads zero
    @(negedge clk); addr = 1'b1; #1;
    check("R1 key address reads zero", rdata, 8'h00);
    // R7 free bits, R1 spare bits stay zero
    put(1'b0, 8'hB4);
    chk_img("R7 free bits written without key", 8'hC4);
    put(1'b0, 8'h00);
    chk_img("R7 free bits cleared", 8'h40);
    // R6 protection
    put(1'b0, 8'h4A);
    chk_img("R6 protected bits locked", 8'h40);
    unlock(); put(1'b0, 8'h42);
    chk_img("R6 write inside window", 8'h42);
    put(1'b0, 8'h40);
    chk_img("R6 window closed by one write", 8'h42);
    unlock(); idle(); idle(); idle(); put(1'b0, 8'h40);
    chk_img("R6 window expired", 8'h42);
    unlock(); idle(); idle(); put(1'b0, 8'h40);
    chk_img("R6 last open clock", 8'h40);
    put(1'b1, 8'hAA); idle(); put(1'b1, 8'h55); put(1'b0, 8'h42);
    chk_img("R6 broken key sequence", 8'h40);
    // R3 / R4 / R8 time-out and watchdog reset
    irq_en = 1'b1;
    unlock(); put(1'b0, 8'h43);
    chk_img("R5 restart bit visible one clock", 8'h43);
    chk_img("R5 restart bit self-clears", 8'h42);
    n = 0;
    while (!irq) begin @(negedge clk); #1; n++; end
    check("R3 time-out period select 0", n, 1024);
    n = 0;
    while (!rst) begin @(negedge clk); #1; n++; end
    check("R4 reset delay after time-out", n, DLY);
    chk_img("R8 cause flag after watchdog reset", 8'h46);
    // R5 restart cancels a pending reset
    while (!irq) @(negedge clk);
    repeat (200) @(negedge clk);
    o0 = obs_pulses;
    unlock(); put(1'b0, 8'h43);
    repeat (700) @(negedge clk);
    check("R5 restart cancels pending reset", obs_pulses, o0);
    repeat (4) begin
      repeat (900) @(negedge clk);
      unlock(); put(1'b0, 8'h43);
      idle();
    end
    chk_img("R5 periodic restart keeps flag clear", 8'h42);
    // R4 no reset with enable low
    unlock(); put(1'b0, 8'h40);
    tsel = 2'd1;
    while (!irq) @(negedge clk);
    o0 = obs_pulses;
    repeat (600) @(negedge clk);
    check("R4 no reset when disabled", obs_pulses, o0);
    // R10 clear collides with time-out
    while (m_cnt != (1 << (B + S)) - 6) @(negedge clk);
    unlock(); idle(); idle(); put(1'b0, 8'h40);
    chk_img("R10 hardware set wins over clear", 8'h48);
    unlock(); put(1'b0, 8'h40);
    chk_img("R10 software clear", 8'h40);
    // R2 power-up flag cleared only by protected write
    put(1'b0, 8'h00);
    chk_img("R2 power flag ignores unprotected write", 8'h40);
    unlock(); put(1'b0, 8'h00);
    chk_img("R2 power flag cleared", 8'h00);
    // R3 another select value
    tsel = 2'd2;
    unlock(); put(1'b0, 8'h01);
    chk_img("R5 restart bit visible", 8'h01);
    chk_img("R5 restart bit cleared", 8'h00);
    n = 0;
    while (!irq) begin @(negedge clk); #1; n++; end
    check("R3 time-out period select 2", n, 4096);
    // R9 external reset
    unlock(); put(1'b0, 8'h02);
    put(1'b0, 8'h86);
    chk_img("R9 setup image", 8'h86);
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    chk_img("R9 external reset keeps cause, enable", 8'h06);
    // count restarted by the external reset; one clock was spent in chk_img
    n = 0;
    while (!irq) begin @(negedge clk); #1; n++; end
    check("R9 external reset restarts count", n, 4095);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule